// File: doc/BRIEF.md
# Hypervisor-Aware Interrupt Enable, Pending and Delegation Registers

This block holds the interrupt state of one hart that supports a hypervisor level: the machine enable word, the software-set part of the pending word and the delegation word. Several CSR addresses map onto these three words. Each address is a view with its own read mask, which decides the bits that reading it returns. Each view also has its own write mask, which decides the bits that a write may change. Sixteen external interrupt lines are ORed into the pending word as the views read it. A configuration input says whether the hypervisor level exists. When it does not, the guest-external enable (bit 12) cannot stay set.

An access is a single-cycle read-modify-write. The view's current masked value is presented on `csr_rdata` while the request is high. On the same clock edge, every writable bit selected by `csr_wmask` takes its value from `csr_wdata`. The block holds no state machine: every access finishes in the cycle it is presented. Privilege checks, trap entry, priority choice and selection of a guest interrupt file are all left to the surrounding core.

Top module: `irq_csr_unit`

## Requirements
- R1: While reset is held and after it is released, the enable word, the delegation word and the software pending bits are all 0, and `claim_o` reads 0x1000 (only bit 12 set).
- R2: Bit positions are as follows. The supervisor bits are software 1, timer 5 and external 9. The virtual-supervisor bits are software 2, timer 6 and external 10. The machine bits are software 3, timer 7 and external 11. Guest external is bit 12. `mip_o` is the software pending word ORed with `irq_lines` on bits 0 to 15.
- R3: Views are selected by `csr_addr` as follows: 0x304 enable, 0x344 pending, 0x303 delegation, 0x104 supervisor enable, 0x144 supervisor pending, 0x604 hypervisor enable, 0x644 hypervisor pending and 0x645 virtual injection. While `csr_req` is high, `csr_rdata` shows the view's value before the access. On the next rising edge, every writable bit with a 1 in `csr_wmask` takes the matching bit of `csr_wdata`. A mask of 0 changes nothing.
- R4: The enable word can hold only bits 1, 2, 3, 5, 6, 7, 9, 10, 11 and 12 (0x1EEE). Every other bit always reads 0.
- R5: With `hyp_present` low, any write that reaches the enable word clears bit 12. This applies to writes through the 0x304, 0x104 and 0x604 views.
- R6: A delegation write takes bits 1, 2, 5, 6, 9 and 10 from the data. With `hyp_present` high, the write then sets bits 2, 6, 10 and 12 to 1.
- R7: The supervisor pending view reads the effective pending word ANDed with the delegation word and 0x222. A write to it can change only pending bit 1, and only while delegation bit 1 is set.
- R8: The hypervisor pending view reads the effective pending word ANDed with 0x1444. A write to it can change only pending bit 2.
- R9: The virtual injection view reads the software pending word ANDed with 0x444. A write to it changes only pending bits 2, 6 and 10.
- R10: The hypervisor enable view reads the enable word ANDed with 0x1444. A write to it changes only those enable bits, and R5 then applies.
- R11: The supervisor enable view reads the enable word ANDed with the delegation word and 0x222. A write to it changes only the enable bits in that same set.
- R12: A write to the machine pending view changes only software pending bits 1, 2, 5, 6, 9 and 10.
- R13: An address outside the R3 list gives `csr_hit` 0 and `csr_rdata` 0, and the access changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hyp_present | input | 1 | The hypervisor level exists |
| csr_req | input | 1 | An access is presented this cycle |
| csr_addr | input | 12 | CSR address of the view |
| csr_wdata | input | XLEN | Write data |
| csr_wmask | input | XLEN | Bits to write |
| irq_lines | input | NLINES | External pending lines |
| csr_rdata | output | XLEN | Masked view value before the access |
| csr_hit | output | 1 | The address names a view |
| mie_o | output | XLEN | Enable word |
| mip_o | output | XLEN | Effective pending word |
| mideleg_o | output | XLEN | Delegation word |
| claim_o | output | XLEN | Claimed-interrupt mask |

## Verification
Several properties are checked on every cycle. The enable word never holds a bit outside its set. The guest enable bit is gone after any enable write made without the hypervisor level. A delegation write with the hypervisor level leaves the forced bits set. The supervisor and hypervisor pending views never return bits outside their masks. A cycle with no effective write leaves the enable and delegation words unchanged. A missed address reads 0.

Only the bench's scenarios can show that each written bit carries the right data value. The same holds for the correct combination of delegation with the supervisor views, and for the external lines reaching the pending views while the injection view ignores them.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;

    localparam int LOCAL_IRQS = 16;

    localparam int B_SSI  = 1;
    localparam int B_VSSI = 2;
    localparam int B_MSI  = 3;
    localparam int B_STI  = 5;
    localparam int B_VSTI = 6;
    localparam int B_MTI  = 7;
    localparam int B_SEI  = 9;
    localparam int B_VSEI = 10;
    localparam int B_MEI  = 11;
    localparam int B_SGEI = 12;

    localparam logic [LOCAL_IRQS-1:0] SET_M  = LOCAL_IRQS'((1 << B_MSI) | (1 << B_MTI) | (1 << B_MEI));
    localparam logic [LOCAL_IRQS-1:0] SET_S  = LOCAL_IRQS'((1 << B_SSI) | (1 << B_STI) | (1 << B_SEI));
    localparam logic [LOCAL_IRQS-1:0] SET_VS = LOCAL_IRQS'((1 << B_VSSI) | (1 << B_VSTI) | (1 << B_VSEI));
    localparam logic [LOCAL_IRQS-1:0] SET_HS = SET_VS | LOCAL_IRQS'(1 << B_SGEI);
    localparam logic [LOCAL_IRQS-1:0] SET_EN = SET_M | SET_S | SET_HS;
    localparam logic [LOCAL_IRQS-1:0] SET_DL = SET_S | SET_VS;
    localparam logic [LOCAL_IRQS-1:0] SET_PW = SET_S | SET_VS;

    localparam logic [11:0] A_MIE     = 12'h304;
    localparam logic [11:0] A_MIP     = 12'h344;
    localparam logic [11:0] A_MIDELEG = 12'h303;
    localparam logic [11:0] A_SIE     = 12'h104;
    localparam logic [11:0] A_SIP     = 12'h144;
    localparam logic [11:0] A_HIE     = 12'h604;
    localparam logic [11:0] A_HIP     = 12'h644;
    localparam logic [11:0] A_HVIP    = 12'h645;

    typedef enum logic [3:0] {
        V_NONE,
        V_MIE,
        V_MIP,
        V_MDLG,
        V_SIE,
        V_SIP,
        V_HIE,
        V_HIP,
        V_HVIP
    } view_e;

endpackage

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
    import irq_csr_pkg::*;
(
    input  logic [11:0] addr,
    output view_e       view,
    output logic        hit
);
    always_comb begin
        unique case (addr)
            A_MIE:     view = V_MIE;
            A_MIP:     view = V_MIP;
            A_MIDELEG: view = V_MDLG;
            A_SIE:     view = V_SIE;
            A_SIP:     view = V_SIP;
            A_HIE:     view = V_HIE;
            A_HIP:     view = V_HIP;
            A_HVIP:    view = V_HVIP;
            default:   view = V_NONE;
        endcase
        hit = (view != V_NONE);
    end
endmodule

// File: rtl/irq_csr_pending.sv
module irq_csr_pending #(
    parameter int XLEN   = 64,
    parameter int NLINES = 16
) (
    input  logic [XLEN-1:0]   sw_pend,
    input  logic [NLINES-1:0] lines,
    output logic [XLEN-1:0]   eff_pend
);
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        if (i < NLINES) begin : g_line
            assign eff_pend[i] = sw_pend[i] | lines[i];
        end else begin : g_soft
            assign eff_pend[i] = sw_pend[i];
        end
    end
endmodule

// File: rtl/irq_csr_readmux.sv
module irq_csr_readmux
    import irq_csr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  view_e           view,
    input  logic            req,
    input  logic [XLEN-1:0] en_q,
    input  logic [XLEN-1:0] dlg_q,
    input  logic [XLEN-1:0] sw_pend,
    input  logic [XLEN-1:0] eff_pend,
    output logic [XLEN-1:0] rdata
);
    localparam logic [XLEN-1:0] MS  = XLEN'(SET_S);
    localparam logic [XLEN-1:0] MHS = XLEN'(SET_HS);
    localparam logic [XLEN-1:0] MVS = XLEN'(SET_VS);

    logic [XLEN-1:0] sel;

    always_comb begin
        unique case (view)
            V_MIE:   sel = en_q;
            V_MIP:   sel = eff_pend;
            V_MDLG:  sel = dlg_q;
            V_SIE:   sel = en_q & dlg_q & MS;
            V_SIP:   sel = eff_pend & dlg_q & MS;
            V_HIE:   sel = en_q & MHS;
            V_HIP:   sel = eff_pend & MHS;
            V_HVIP:  sel = sw_pend & MVS;
            default: sel = '0;
        endcase
        rdata = req ? sel : '0;
    end
endmodule

// File: rtl/irq_csr_state.sv
module irq_csr_state
    import irq_csr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hyp_present,
    input  logic            req,
    input  view_e           view,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] wmask,
    output logic [XLEN-1:0] en_q,
    output logic [XLEN-1:0] dlg_q,
    output logic [XLEN-1:0] pend_q,
    output logic [XLEN-1:0] claim_q
);
    localparam logic [XLEN-1:0] MEN  = XLEN'(SET_EN);
    localparam logic [XLEN-1:0] MS   = XLEN'(SET_S);
    localparam logic [XLEN-1:0] MHS  = XLEN'(SET_HS);
    localparam logic [XLEN-1:0] MVS  = XLEN'(SET_VS);
    localparam logic [XLEN-1:0] MDL  = XLEN'(SET_DL);
    localparam logic [XLEN-1:0] MPW  = XLEN'(SET_PW);
    localparam logic [XLEN-1:0] MSSI = XLEN'(1) << B_SSI;
    localparam logic [XLEN-1:0] MVSS = XLEN'(1) << B_VSSI;
    localparam logic [XLEN-1:0] MSGE = XLEN'(1) << B_SGEI;

    logic            wr;
    logic            en_touch;
    logic [XLEN-1:0] sel;
    logic [XLEN-1:0] en_d;
    logic [XLEN-1:0] dlg_d;
    logic [XLEN-1:0] pend_d;

    assign wr = req && (view != V_NONE) && (|wmask);

    always_comb begin
        en_d     = en_q;
        dlg_d    = dlg_q;
        pend_d   = pend_q;
        en_touch = 1'b0;
        sel      = '0;
        if (wr) begin
            unique case (view)
                V_MIE: begin
                    sel      = wmask & MEN;
                    en_d     = (en_q & ~sel) | (wdata & sel);
                    en_touch = 1'b1;
                end
                V_SIE: begin
                    sel      = wmask & MS & dlg_q;
                    en_d     = (en_q & ~sel) | (wdata & sel);
                    en_touch = 1'b1;
                end
                V_HIE: begin
                    sel      = wmask & MHS;
                    en_d     = (en_q & ~sel) | (wdata & sel);
                    en_touch = 1'b1;
                end
                V_MIP: begin
                    sel    = wmask & MPW;
                    pend_d = (pend_q & ~sel) | (wdata & sel);
                end
                V_SIP: begin
                    sel    = wmask & MSSI & dlg_q;
                    pend_d = (pend_q & ~sel) | (wdata & sel);
                end
                V_HIP: begin
                    sel    = wmask & MVSS;
                    pend_d = (pend_q & ~sel) | (wdata & sel);
                end
                V_HVIP: begin
                    sel    = wmask & MVS;
                    pend_d = (pend_q & ~sel) | (wdata & sel);
                end
                V_MDLG: begin
                    sel   = wmask & MDL;
                    dlg_d = (dlg_q & ~sel) | (wdata & sel);
                    if (hyp_present) begin
                        dlg_d = dlg_d | MHS;
                    end
                end
                default: begin
                end
            endcase
            if (en_touch && !hyp_present) begin
                en_d = en_d & ~MSGE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            dlg_q   <= '0;
            pend_q  <= '0;
            claim_q <= MSGE;
        end else begin
            en_q   <= en_d;
            dlg_q  <= dlg_d;
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/irq_csr_unit.sv
module irq_csr_unit
    import irq_csr_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NLINES = LOCAL_IRQS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hyp_present,
    input  logic              csr_req,
    input  logic [11:0]       csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [XLEN-1:0]   csr_wmask,
    input  logic [NLINES-1:0] irq_lines,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_hit,
    output logic [XLEN-1:0]   mie_o,
    output logic [XLEN-1:0]   mip_o,
    output logic [XLEN-1:0]   mideleg_o,
    output logic [XLEN-1:0]   claim_o
);
    view_e           view;
    logic            dec_hit;
    logic [XLEN-1:0] en_q;
    logic [XLEN-1:0] dlg_q;
    logic [XLEN-1:0] pend_q;
    logic [XLEN-1:0] claim_q;
    logic [XLEN-1:0] eff_pend;

    irq_csr_decode u_dec (
        .addr (csr_addr),
        .view (view),
        .hit  (dec_hit)
    );

    irq_csr_pending #(.XLEN(XLEN), .NLINES(NLINES)) u_pend (
        .sw_pend  (pend_q),
        .lines    (irq_lines),
        .eff_pend (eff_pend)
    );

    irq_csr_state #(.XLEN(XLEN)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .hyp_present (hyp_present),
        .req         (csr_req),
        .view        (view),
        .wdata       (csr_wdata),
        .wmask       (csr_wmask),
        .en_q        (en_q),
        .dlg_q       (dlg_q),
        .pend_q      (pend_q),
        .claim_q     (claim_q)
    );

    irq_csr_readmux #(.XLEN(XLEN)) u_rd (
        .view     (view),
        .req      (csr_req),
        .en_q     (en_q),
        .dlg_q    (dlg_q),
        .sw_pend  (pend_q),
        .eff_pend (eff_pend),
        .rdata    (csr_rdata)
    );

    assign csr_hit   = dec_hit;
    assign mie_o     = en_q;
    assign mip_o     = eff_pend;
    assign mideleg_o = dlg_q;
    assign claim_o   = claim_q;
endmodule

// File: rtl/irq_csr_unit_chk.sv
module irq_csr_unit_chk
    import irq_csr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hyp_present,
    input logic            csr_req,
    input logic [11:0]     csr_addr,
    input logic [XLEN-1:0] csr_wmask,
    input logic [XLEN-1:0] csr_rdata,
    input logic            csr_hit,
    input logic [XLEN-1:0] mie_o,
    input logic [XLEN-1:0] mideleg_o,
    input logic [XLEN-1:0] claim_o
);
    localparam logic [XLEN-1:0] MEN = XLEN'(SET_EN);
    localparam logic [XLEN-1:0] MS  = XLEN'(SET_S);
    localparam logic [XLEN-1:0] MHS = XLEN'(SET_HS);

    logic en_write;
    logic any_write;
    assign en_write  = csr_req && (|csr_wmask) &&
                       (csr_addr == A_MIE || csr_addr == A_SIE || csr_addr == A_HIE);
    assign any_write = csr_req && csr_hit && (|csr_wmask);

    // R1
    claim_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o == (XLEN'(1) << B_SGEI));

    // R4
    en_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mie_o & ~MEN) == '0);

    // R5
    sgei_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_write && !hyp_present) |=> (mie_o[B_SGEI] == 1'b0));

    // R6
    dlg_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_addr == A_MIDELEG && (|csr_wmask) && hyp_present)
        |=> ((mideleg_o & MHS) == MHS));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_write |=> ($stable(mie_o) && $stable(mideleg_o)));

    // R7
    sip_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_addr == A_SIP) |-> ((csr_rdata & ~MS) == '0));

    // R8
    hip_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_addr == A_HIP) |-> ((csr_rdata & ~MHS) == '0));

    // R13
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !csr_hit) |-> (csr_rdata == '0));
endmodule

bind irq_csr_unit irq_csr_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hyp_present (hyp_present),
    .csr_req     (csr_req),
    .csr_addr    (csr_addr),
    .csr_wmask   (csr_wmask),
    .csr_rdata   (csr_rdata),
    .csr_hit     (csr_hit),
    .mie_o       (mie_o),
    .mideleg_o   (mideleg_o),
    .claim_o     (claim_o)
);

// File: tb/tb_irq_csr_unit.sv
`timescale 1ns/1ps
module tb_irq_csr_unit;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hyp_present = 1'b1;
    logic            csr_req = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_wmask = '0;
    logic [15:0]     irq_lines = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_hit;
    logic [XLEN-1:0] mie_o, mip_o, mideleg_o, claim_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [XLEN-1:0] m_en = '0, m_dl = '0, m_pd = '0;

    always #2.5 clk = ~clk;

    irq_csr_unit #(.XLEN(XLEN), .NLINES(16)) dut (
        .clk(clk), .rst_n(rst_n), .hyp_present(hyp_present),
        .csr_req(csr_req), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_wmask(csr_wmask), .irq_lines(irq_lines), .csr_rdata(csr_rdata),
        .csr_hit(csr_hit), .mie_o(mie_o), .mip_o(mip_o),
        .mideleg_o(mideleg_o), .claim_o(claim_o)
    );

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [11:0] a);
        case (a)
            12'h304: return "R4";
            12'h344: return "R12";
            12'h303: return "R6";
            12'h104: return "R11";
            12'h144: return "R7";
            12'h604: return "R10";
            12'h644: return "R8";
            12'h645: return "R9";
            default: return "R13";
        endcase
    endfunction

    function automatic logic [XLEN-1:0] eff();
        return m_pd | {48'h0, irq_lines};
    endfunction

    function automatic logic [XLEN-1:0] mdl_read(input logic [11:0] a);
        case (a)
            12'h304: return m_en;
            12'h344: return eff();
            12'h303: return m_dl;
            12'h104: return m_en & m_dl & 64'h222;
            12'h144: return eff() & m_dl & 64'h222;
            12'h604: return m_en & 64'h1444;
            12'h644: return eff() & 64'h1444;
            12'h645: return m_pd & 64'h444;
            default: return '0;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] merge(input logic [XLEN-1:0] old, input logic [XLEN-1:0] d,
                                              input logic [XLEN-1:0] msk);
        return (old & ~msk) | (d & msk);
    endfunction

    task automatic mdl_write(input logic [11:0] a, input logic [XLEN-1:0] d, input logic [XLEN-1:0] m);
        bit touch = 0;
        if (m == '0) return;
        case (a)
            12'h304: begin m_en = merge(m_en, d, m & 64'h1EEE); touch = 1; end
            12'h104: begin m_en = merge(m_en, d, m & 64'h222 & m_dl); touch = 1; end
            12'h604: begin m_en = merge(m_en, d, m & 64'h1444); touch = 1; end
            12'h344: m_pd = merge(m_pd, d, m & 64'h666);
            12'h144: m_pd = merge(m_pd, d, m & 64'h2 & m_dl);
            12'h644: m_pd = merge(m_pd, d, m & 64'h4);
            12'h645: m_pd = merge(m_pd, d, m & 64'h444);
            12'h303: begin
                m_dl = merge(m_dl, d, m & 64'h666);
                if (hyp_present) m_dl = m_dl | 64'h1444;
            end
            default: ;
        endcase
        if (touch && !hyp_present) m_en[12] = 1'b0;
    endtask

    task automatic access(input logic [11:0] a, input logic [XLEN-1:0] d, input logic [XLEN-1:0] m);
        string t;
        logic [XLEN-1:0] rexp;
        t = tag_of(a);
        @(negedge clk);
        csr_req = 1'b1; csr_addr = a; csr_wdata = d; csr_wmask = m;
        #1;
        rexp = mdl_read(a);
        check({t, " rdata (R3)"}, csr_rdata, rexp);
        mdl_write(a, d, m);
        @(posedge clk);
        #1;
        csr_req = 1'b0;
        check({t, " enable word"}, mie_o, m_en);
        check({t, " delegation word"}, mideleg_o, m_dl);
        check({t, " pending word (R2)"}, mip_o, eff());
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    logic [11:0] addrs [9] = '{12'h304, 12'h344, 12'h303, 12'h104, 12'h144,
                               12'h604, 12'h644, 12'h645, 12'h300};

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 enable", mie_o, '0);
        check("R1 delegation", mideleg_o, '0);
        check("R1 pending", mip_o, '0);
        check("R1 claim", claim_o, 64'h1000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 claim after release", claim_o, 64'h1000);

        // R4 full enable write with hypervisor present
        access(12'h304, '1, '1);
        check("R4 enable all ones", mie_o, 64'h1EEE);
        // R3 zero mask changes nothing
        access(12'h304, '0, '0);
        check("R3 zero mask", mie_o, 64'h1EEE);
        // R6 delegation forced bits
        access(12'h303, '0, '1);
        check("R6 forced only", mideleg_o, 64'h1444);
        access(12'h303, '1, '1);
        check("R6 all delegable", mideleg_o, 64'h1666);
        // R2 external lines reach pending views, R9 injection view ignores them
        @(negedge clk); irq_lines = 16'h1E22;
        access(12'h644, '0, '0);
        access(12'h645, '0, '0);
        access(12'h144, '0, '0);
        // R13 unknown address
        @(negedge clk);
        csr_req = 1'b1; csr_addr = 12'h300; csr_wdata = '1; csr_wmask = '1;
        #1;
        check("R13 hit", {63'h0, csr_hit}, '0);
        access(12'h300, '1, '1);
        // R5 hypervisor absent clears guest enable via each view
        @(negedge clk); hyp_present = 1'b0; irq_lines = '0;
        access(12'h604, 64'h1000, 64'h1000);
        check("R5 via hypervisor view", mie_o & 64'h1000, '0);
        access(12'h104, '0, 64'h2);
        check("R5 via supervisor view", mie_o & 64'h1000, '0);
        // R11 supervisor enable respects delegation
        access(12'h303, '0, 64'h2);
        access(12'h104, '1, '1);
        check("R11 undelegated bit kept", mie_o & 64'h2, '0);

        // random phase, hypervisor present then absent
        for (int ph = 0; ph < 2; ph++) begin
            @(negedge clk); hyp_present = (ph == 0);
            for (int i = 0; i < 300; i++) begin
                logic [XLEN-1:0] d, m;
                int k, sel;
                k = $urandom_range(0, 8);
                d = {$urandom, $urandom};
                sel = $urandom_range(0, 3);
                m = (sel == 0) ? '0 : (sel == 1) ? '1 : {$urandom, $urandom};
                if ($urandom_range(0, 4) == 0) begin
                    @(negedge clk); irq_lines = 16'($urandom);
                end
                access(addrs[k], d, m);
            end
        end

        done = 1;
        finish_run();
    end
endmodule